// File: doc/BRIEF.md
# Three-Stage Ready/Valid Stream Pipeline

This block carries a 24-bit data stream through three register stages. Items enter through a ready/valid receiving port and leave through a ready/valid sending port. Both ports run on one clock. An item crosses a port only in a cycle where both valid and ready are high at the same rising edge. The handshake keeps no history: whether a transfer happens in a cycle depends only on the signal levels in that cycle.

Each stage holds at most one item and has its own occupied flag. A stage takes a new item when it is empty, or when the stage after it is handing its item on in the same cycle. Because of this rule, empty slots (bubbles) close up while the output is stalled. An empty pipeline accepts items at full rate whatever the downstream side does, until all three stages are full.

Between the stages, a per-stage transform hook passes data through unchanged, so the block suits designs that later split combinational work over several cycles without losing throughput. A synchronous active-low reset empties every stage.

Top module: `rv_pipe3`

## Requirements
- R1: Every item accepted on the input (a cycle with in_valid and in_ready both high) leaves on the output exactly once, in acceptance order. No item is lost, duplicated or invented.
- R2: An item accepted in cycle c into an empty pipeline, with out_ready held high, shows out_valid high first in cycle c+3 and not in cycles c+1 or c+2.
- R3: With in_valid and out_ready held high continuously, one item leaves on every cycle once the first item has arrived, and in_ready stays high throughout.
- R4: Once out_valid is high in a cycle where out_ready is low, out_valid stays high in the next cycle and out_data stays unchanged.
- R5: in_ready is high whenever the pipeline holds fewer than three items, whatever the level of out_ready. With three items held and out_ready low, in_ready is low.
- R6: While rst_n is low at a rising edge, every stage is emptied. In the cycle after reset out_valid is low and in_ready is high, and no item held before the reset is ever emitted.
- R7: With three items held, out_ready high and in_valid high, in_ready is high, and the pipeline both emits and accepts an item in that same cycle.
- R8: The data is passed through unchanged: out_data of each emitted item equals the in_data value that was accepted for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream offers an item |
| in_data | input | 24 | Offered item |
| in_ready | output | 1 | Pipeline can take an item this cycle |
| out_valid | output | 1 | Pipeline offers an item |
| out_data | output | 24 | Offered item |
| out_ready | input | 1 | Downstream takes the offered item this cycle |

## Verification
The two functions that can fall in the same cycle are emitting the oldest item and accepting a new one while all three stages are full. A directed sequence first fills the pipeline with out_ready low, then raises out_ready and in_valid together. The bench checks that in_ready is high in that cycle, and the scoreboard then confirms that both items arrive in order. Long random stall bursts on out_ready, mixed with random gaps on in_valid, produce the same overlap many times, and each emitted item is compared with the queue of accepted ones.

// File: rtl/rvpipe_pkg.sv
// Package: shared sizing for the three-stage ready/valid pipeline.
// Assumes: all users import it before declaring ports.
package rvpipe_pkg;
    parameter int unsigned RVP_DATA_W = 24;  // item width on both ports
    parameter int unsigned RVP_STAGES = 3;   // register stages, equals latency
endpackage

// File: rtl/rvpipe_xform.sv
// Module: per-stage transform hook.
// Does: applies the combinational work assigned to one stage; today an identity.
// Assumes: purely combinational, no state, same width in and out.
module rvpipe_xform #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Identity pass-through; replace with stage work when a function is split.
    always_comb q = d;
endmodule

// File: rtl/rvpipe_stage.sv
// Module: one ready/valid register stage.
// Does: holds at most one item and hands it on when downstream is ready.
//       Loads when empty or when its own item leaves in the same cycle.
// Assumes: single clock; synchronous active-low reset clears only the flag.
module rvpipe_stage #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    input  logic [W-1:0] up_data,
    output logic         up_ready,
    output logic         dn_valid,
    output logic [W-1:0] dn_data,
    input  logic         dn_ready
);
    logic         held;
    logic [W-1:0] slot;
    logic [W-1:0] worked;

    rvpipe_xform #(.W(W)) u_xf (.d(up_data), .q(worked));

    // Open to upstream when empty or when the held item drains now.
    always_comb up_ready = !held || dn_ready;

    // Occupied flag: follows the upstream offer whenever the slot is open.
    always_ff @(posedge clk) begin
        if (!rst_n)        held <= 1'b0;
        else if (up_ready) held <= up_valid;
    end

    // Data slot: captures only on a real handshake; no reset needed.
    always_ff @(posedge clk) begin
        if (up_ready && up_valid) slot <= worked;
    end

    assign dn_valid = held;
    assign dn_data  = slot;

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

    // R6
    rst_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !dn_valid);
endmodule

// File: rtl/rv_pipe3.sv
// Module: three-stage ready/valid pipeline, top level.
// Does: chains RVP_STAGES register stages between a receiving and a sending
//       ready/valid port; bubbles collapse under backpressure.
// Assumes: one clock for both ports; synchronous active-low reset.
module rv_pipe3
    import rvpipe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [RVP_DATA_W-1:0] in_data,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [RVP_DATA_W-1:0] out_data,
    input  logic                  out_ready
);
    localparam int unsigned N  = RVP_STAGES;
    localparam int unsigned OW = $clog2(N + 1) + 1;

    logic                  lnk_v [0:N];
    logic                  lnk_r [0:N];
    logic [RVP_DATA_W-1:0] lnk_d [0:N];

    assign lnk_v[0] = in_valid;
    assign lnk_d[0] = in_data;
    assign in_ready = lnk_r[0];
    assign lnk_r[N] = out_ready;
    assign out_valid = lnk_v[N];
    assign out_data  = lnk_d[N];

    for (genvar g = 0; g < N; g++) begin : g_stage
        rvpipe_stage #(.W(RVP_DATA_W)) u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_valid (lnk_v[g]),
            .up_data  (lnk_d[g]),
            .up_ready (lnk_r[g]),
            .dn_valid (lnk_v[g+1]),
            .dn_data  (lnk_d[g+1]),
            .dn_ready (lnk_r[g+1])
        );
    end

    // Checker state: items held, tracked from port handshakes only.
    logic [OW-1:0] occ;
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + OW'(in_valid && in_ready) - OW'(out_valid && out_ready);
    end

    // R1
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(N));

    // R1
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !out_valid);

    // R5
    bubble_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < OW'(N)) |-> in_ready);

    // R7
    drain_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ == OW'(N)) && out_ready) |-> in_ready);

    // R5
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ == OW'(N)) && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_rv_pipe3.sv
module sim_rv_pipe3;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [23:0] out_data;
    logic        out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int n_in   = 0;
    int n_out  = 0;
    bit done   = 1'b0;
    logic [23:0] expq [$];
    logic        prev_stall = 1'b0;
    logic [23:0] prev_data  = '0;

    always #5 clk = ~clk;

    rv_pipe3 u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs for the next cycle, just after the rising edge.
    task automatic step(input bit iv, input bit ordy);
        @(posedge clk); #1;
        in_valid  = iv;
        in_data   = 24'($urandom);
        out_ready = ordy;
    endtask

    // Monitor: records accepted items, compares emitted ones, checks port rules.
    always @(negedge clk) begin
        if (!rst_n) begin
            expq.delete();
            n_in = 0; n_out = 0;
            prev_stall = 1'b0;
        end else begin
            int occ;
            occ = n_in - n_out;
            if (prev_stall) begin
                check(out_valid == 1'b1, "R4 valid held", 32'(out_valid), 32'd1);
                check(out_data == prev_data, "R4 data held", 32'(out_data), 32'(prev_data));
            end
            if (occ < 3) check(in_ready == 1'b1, "R5 ready with room", 32'(in_ready), 32'd1);
            if (occ == 3 && !out_ready) check(in_ready == 1'b0, "R5 blocked when full", 32'(in_ready), 32'd0);
            if (occ == 3 && out_ready) check(in_ready == 1'b1, "R7 drain and fill", 32'(in_ready), 32'd1);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R1 unexpected item", 32'(out_data), 32'd0);
                end else begin
                    logic [23:0] e;
                    e = expq.pop_front();
                    check(out_data == e, "R8 R1 item value and order", 32'(out_data), 32'(e));
                end
                n_out++;
            end
            if (in_valid && in_ready) begin
                expq.push_back(in_data);
                n_in++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int base;
        int stall;
        // Reset state (R6)
        repeat (3) step(1'b0, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R6 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R6 in_ready after reset", 32'(in_ready), 32'd1);

        // Latency into an empty pipeline (R2)
        step(1'b1, 1'b1);
        for (int k = 1; k <= 3; k++) begin
            step(1'b0, 1'b1);
            @(negedge clk);
            check(out_valid == (k == 3), "R2 latency", 32'(out_valid), 32'(k == 3));
        end
        repeat (4) step(1'b0, 1'b1);

        // Full-rate streaming (R3)
        base = n_out;
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 1'b1);
            @(negedge clk);
            check(in_ready == 1'b1, "R3 in_ready while streaming", 32'(in_ready), 32'd1);
            if (i >= 3) check(out_valid == 1'b1, "R3 one item per cycle", 32'(out_valid), 32'd1);
        end
        repeat (4) step(1'b0, 1'b1);
        @(negedge clk);
        check(n_out - base == 30, "R3 streamed count", 32'(n_out - base), 32'd30);

        // Fill under stall, then drain and fill together (R5, R7)
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        @(negedge clk);
        check(in_ready == 1'b0, "R5 full and stalled", 32'(in_ready), 32'd0);
        check(n_in - n_out == 3, "R5 three held", 32'(n_in - n_out), 32'd3);
        step(1'b1, 1'b1);
        @(negedge clk);
        check(in_ready == 1'b1, "R7 simultaneous accept", 32'(in_ready), 32'd1);
        check(out_valid == 1'b1, "R7 simultaneous emit", 32'(out_valid), 32'd1);

        // Random traffic with long stall bursts (R1, R4, R5, R8)
        stall = 0;
        for (int i = 0; i < 4000; i++) begin
            bit r;
            if (stall > 0) begin
                stall--;
                r = 1'b0;
            end else begin
                if ($urandom_range(0, 19) == 0) stall = $urandom_range(5, 40);
                r = ($urandom_range(0, 3) != 0);
            end
            step($urandom_range(0, 2) != 0, r);
        end

        // Reset with items inside (R6)
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        @(posedge clk); #1 rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R6 emptied by reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R6 ready after reset", 32'(in_ready), 32'd1);
        repeat (6) begin
            step(1'b0, 1'b1);
            @(negedge clk);
            check(out_valid == 1'b0, "R6 no stale item", 32'(out_valid), 32'd0);
        end

        // Short tail of traffic, then drain and confirm nothing is lost (R1)
        for (int i = 0; i < 50; i++) step(1'b1, $urandom_range(0, 1) == 1);
        repeat (8) step(1'b0, 1'b1);
        @(negedge clk);
        check(expq.size() == 0, "R1 all items delivered", 32'(expq.size()), 32'd0);
        check(n_in == n_out, "R1 in and out counts", 32'(n_out), 32'(n_in));
        finish_run();
    end
endmodule